// File: doc/BRIEF.md
# Operating-Point Power and Clock Manager

This block turns one register write into a full, ordered change of the chip's power and clock configuration. A bus master loads three small tables while the manager is idle: a table of operating points, a table of legal per-domain power-state combinations, and a table of per-block clock dividers. Each operating point names one power-state row, one divider row, and the multiply and divide factors for each domain's single PLL. Writing an operating-point number to the request register is the only way to change the configuration.

The manager then walks a fixed sequence. First it applies the new power states to every domain together and waits a programmable power-settling time. Then it applies the new divider row and PLL factors and waits a programmable PLL-settling time. A step whose target already matches the live state is skipped without a wait. The done strobe is raised only after all settling has ended. A divider of zero gates that block's clock. A block in a domain that is off is also gated.

The manager also watches functional access strobes for each block. An access to a gated block that has no wake-up capability records a sticky error together with the block number. Requests made while busy and requests for rows that do not exist are rejected, and each sets its own sticky flag.

Top module: `opm_ctrl`

## Requirements
- R1: After reset: the live row is 0, every domain is on (code 2'b10), every divider is 1, every PLL multiply and divide factor is 1, all clocks are enabled, and busy, done and all flags are 0.
- R2: A write to address 0x00 while idle, with data below NUM_OPP, raises busy_o from the next cycle. The number of busy cycles is 3, plus P+1 if the power states change, plus Q+1 if the clock setting changes. P and Q are the settling counts. done_o is high for exactly one cycle, the last busy cycle, and cur_opp_o then shows the new row.
- R3: Power states change before any clock setting. P is written at address 0x01, data[7:0]. Domain d's state is at pwr_state_o[2d+1:2d] with codes 00 off, 01 scaled, 10 on.
- R4: The divider and PLL factors are applied after power settling. Q is written at address 0x01, data[15:8]. A request whose rows match the live state completes in 3 busy cycles.
- R5: An operating-point row is written at 0x10+i with these fields: power row index in data[1:0], divider row index in data[9:8], and for domain d the PLL multiply in data[16+8d+3:16+8d] and the PLL divide in data[20+8d+3:20+8d]. A power row is written at 0x20+i with 2 bits per domain. A divider row is written at 0x30+i with 4 bits per block, block b at [4b+3:4b]. After a request, the outputs carry the selected rows.
- R6: clk_en_o[b] is 1 only when block b's divider is nonzero and its domain (b / BLK_PER_DOM) is not off.
- R7: A request written while busy is ignored and sets ovr_flag_o. The running change still completes to its own target.
- R8: A request whose data is NUM_OPP or more sets inv_flag_o. busy_o stays low and all outputs keep their values.
- R9: Table writes and settling-count writes made while busy are ignored.
- R10: An access strobe for a block that is clock-disabled and has no wake-up capability (bit clear in WAKE_MASK) sets err_flag_o on the next cycle. err_blk_o holds the lowest such block. The first error's block number is kept until the flag is cleared.
- R11: A write to 0x02 clears ovr_flag_o with data bit 0, inv_flag_o with bit 1 and err_flag_o with bit 2. A new error in the same cycle as a clear takes precedence over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register address |
| wr_data_i | input | 32 | Register write data |
| acc_valid_i | input | NUM_DOM*BLK_PER_DOM | Functional access strobe per block |
| pwr_state_o | output | 2*NUM_DOM | Power state per domain |
| clk_div_o | output | NUM_DOM*BLK_PER_DOM*DIV_W | Clock divider per block |
| clk_en_o | output | NUM_DOM*BLK_PER_DOM | Clock enable per block |
| pll_mul_o | output | NUM_DOM*PLL_W | PLL multiply factor per domain |
| pll_div_o | output | NUM_DOM*PLL_W | PLL divide factor per domain |
| busy_o | output | 1 | Change in progress |
| done_o | output | 1 | One-cycle completion strobe |
| cur_opp_o | output | $clog2(NUM_OPP) | Live operating-point row |
| ovr_flag_o | output | 1 | Sticky: request written while busy |
| inv_flag_o | output | 1 | Sticky: request for a nonexistent row |
| err_flag_o | output | 1 | Sticky: access to a gated block |
| err_blk_o | output | $clog2(NUM_DOM*BLK_PER_DOM) | Block of the first recorded access error |

## Verification
Busy starts one clock edge after the request write and lasts 3, 3+P+1, 3+Q+1 or 5+P+Q cycles, depending on which steps are needed. The bench counts busy cycles at falling edges and compares the count with that formula for each kind of change, including a re-request of the live row. Sticky flags and the access error register one edge after their cause, so each check samples at the falling edge that follows the stimulus edge. Outputs are compared only after busy has dropped.

// File: rtl/opm_pkg.sv
// Shared constants for the operating-point manager: power-state codes,
// register addresses and the sequencer state encoding.
package opm_pkg;
    localparam logic [1:0] PWR_OFF    = 2'b00;
    localparam logic [1:0] PWR_SCALED = 2'b01;
    localparam logic [1:0] PWR_ON     = 2'b10;

    localparam logic [7:0] A_REQ    = 8'h00;
    localparam logic [7:0] A_SETTLE = 8'h01;
    localparam logic [7:0] A_CLR    = 8'h02;

    localparam logic [3:0] PG_OPP = 4'h1;
    localparam logic [3:0] PG_PST = 4'h2;
    localparam logic [3:0] PG_CST = 4'h3;

    typedef enum logic [2:0] {
        S_IDLE, S_LOOK, S_PWAIT, S_CLK, S_CWAIT, S_FIN
    } seq_st_t;
endpackage

// File: rtl/opm_tables.sv
// Holds the three linked tables and resolves one operating-point row into
// its power row, divider row and PLL factors.
// Assumes power-of-two depths of at most 16 and NUM_DOM <= 2 (field lanes).
module opm_tables #(
    parameter int NUM_OPP = 4,
    parameter int NUM_PST = 4,
    parameter int NUM_CST = 4,
    parameter int NUM_DOM = 2,
    parameter int NUM_BLK = 4,
    parameter int DIV_W   = 4,
    parameter int PLL_W   = 4,
    localparam int OPP_W  = $clog2(NUM_OPP),
    localparam int PST_W  = $clog2(NUM_PST),
    localparam int CST_W  = $clog2(NUM_CST)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tab_we,
    input  logic [7:0]                 wr_addr,
    input  logic [31:0]                wr_data,
    input  logic [OPP_W-1:0]           sel_opp,
    output logic [2*NUM_DOM-1:0]       row_pwr,
    output logic [NUM_BLK*DIV_W-1:0]   row_div,
    output logic [NUM_DOM*PLL_W-1:0]   row_mul,
    output logic [NUM_DOM*PLL_W-1:0]   row_pdiv
);
    import opm_pkg::*;

    localparam logic [2*NUM_DOM-1:0]     PWR_ALL_ON = {NUM_DOM{PWR_ON}};
    localparam logic [NUM_BLK*DIV_W-1:0] DIV_ONES   = {NUM_BLK{DIV_W'(1)}};
    localparam logic [NUM_DOM*PLL_W-1:0] PLL_ONES   = {NUM_DOM{PLL_W'(1)}};

    logic [PST_W-1:0]           opp_pst_q  [NUM_OPP];
    logic [CST_W-1:0]           opp_cst_q  [NUM_OPP];
    logic [NUM_DOM*PLL_W-1:0]   opp_mul_q  [NUM_OPP];
    logic [NUM_DOM*PLL_W-1:0]   opp_pdiv_q [NUM_OPP];
    logic [2*NUM_DOM-1:0]       pst_q      [NUM_PST];
    logic [NUM_BLK*DIV_W-1:0]   cst_q      [NUM_CST];

    logic [NUM_DOM*PLL_W-1:0]   wr_mul, wr_pdiv;
    logic                       hit_opp, hit_pst, hit_cst;

    // Unpack per-domain PLL factors from their fixed byte lanes.
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_lane
        assign wr_mul[d*PLL_W +: PLL_W]  = wr_data[16+8*d +: PLL_W];
        assign wr_pdiv[d*PLL_W +: PLL_W] = wr_data[20+8*d +: PLL_W];
    end

    // Decode which table row the current write targets.
    always_comb begin
        hit_opp = tab_we && wr_addr[7:4] == PG_OPP && 32'(wr_addr[3:0]) < NUM_OPP;
        hit_pst = tab_we && wr_addr[7:4] == PG_PST && 32'(wr_addr[3:0]) < NUM_PST;
        hit_cst = tab_we && wr_addr[7:4] == PG_CST && 32'(wr_addr[3:0]) < NUM_CST;
    end

    // Table storage: reset to the all-on, divide-by-one configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_OPP; i++) begin
                opp_pst_q[i]  <= '0;
                opp_cst_q[i]  <= '0;
                opp_mul_q[i]  <= PLL_ONES;
                opp_pdiv_q[i] <= PLL_ONES;
            end
            for (int i = 0; i < NUM_PST; i++) pst_q[i] <= PWR_ALL_ON;
            for (int i = 0; i < NUM_CST; i++) cst_q[i] <= DIV_ONES;
        end else begin
            if (hit_opp) begin
                opp_pst_q[wr_addr[OPP_W-1:0]]  <= wr_data[PST_W-1:0];
                opp_cst_q[wr_addr[OPP_W-1:0]]  <= wr_data[8 +: CST_W];
                opp_mul_q[wr_addr[OPP_W-1:0]]  <= wr_mul;
                opp_pdiv_q[wr_addr[OPP_W-1:0]] <= wr_pdiv;
            end
            if (hit_pst) pst_q[wr_addr[PST_W-1:0]] <= wr_data[2*NUM_DOM-1:0];
            if (hit_cst) cst_q[wr_addr[CST_W-1:0]] <= wr_data[NUM_BLK*DIV_W-1:0];
        end
    end

    // Chained lookup: operating point -> power row, divider row, PLL factors.
    always_comb begin
        row_pwr  = pst_q[opp_pst_q[sel_opp]];
        row_div  = cst_q[opp_cst_q[sel_opp]];
        row_mul  = opp_mul_q[sel_opp];
        row_pdiv = opp_pdiv_q[sel_opp];
    end
endmodule

// File: rtl/opm_seq.sv
// Sequencer: applies power states, waits the power settling count, then
// applies dividers and PLL factors and waits the PLL settling count.
// Steps whose target equals the live state are skipped. Assumes the row
// inputs stay stable while busy (tables are write-locked then).
module opm_seq #(
    parameter int NUM_OPP = 4,
    parameter int NUM_DOM = 2,
    parameter int NUM_BLK = 4,
    parameter int DIV_W   = 4,
    parameter int PLL_W   = 4,
    parameter int SET_W   = 8,
    localparam int OPP_W  = $clog2(NUM_OPP)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [OPP_W-1:0]           start_idx,
    input  logic [2*NUM_DOM-1:0]       row_pwr,
    input  logic [NUM_BLK*DIV_W-1:0]   row_div,
    input  logic [NUM_DOM*PLL_W-1:0]   row_mul,
    input  logic [NUM_DOM*PLL_W-1:0]   row_pdiv,
    input  logic [SET_W-1:0]           pwr_settle,
    input  logic [SET_W-1:0]           pll_settle,
    output logic [2*NUM_DOM-1:0]       pwr_q,
    output logic [NUM_BLK*DIV_W-1:0]   div_q,
    output logic [NUM_DOM*PLL_W-1:0]   mul_q,
    output logic [NUM_DOM*PLL_W-1:0]   pdiv_q,
    output logic [OPP_W-1:0]           tgt_q,
    output logic [OPP_W-1:0]           cur_q,
    output logic                       busy,
    output logic                       done
);
    import opm_pkg::*;

    seq_st_t           st;
    logic [SET_W-1:0]  cnt;
    logic              clk_change;

    // Detect whether the clock step has anything to apply.
    always_comb clk_change = (row_div != div_q) || (row_mul != mul_q) || (row_pdiv != pdiv_q);

    // Main sequencing state machine with its settling counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            cnt    <= '0;
            tgt_q  <= '0;
            cur_q  <= '0;
            pwr_q  <= {NUM_DOM{PWR_ON}};
            div_q  <= {NUM_BLK{DIV_W'(1)}};
            mul_q  <= {NUM_DOM{PLL_W'(1)}};
            pdiv_q <= {NUM_DOM{PLL_W'(1)}};
        end else begin
            unique case (st)
                S_IDLE: if (start) begin
                    tgt_q <= start_idx;
                    st    <= S_LOOK;
                end
                S_LOOK: if (row_pwr != pwr_q) begin
                    pwr_q <= row_pwr;
                    cnt   <= pwr_settle;
                    st    <= S_PWAIT;
                end else begin
                    st <= S_CLK;
                end
                S_PWAIT: if (cnt == '0) st <= S_CLK; else cnt <= cnt - 1'b1;
                S_CLK: if (clk_change) begin
                    div_q  <= row_div;
                    mul_q  <= row_mul;
                    pdiv_q <= row_pdiv;
                    cnt    <= pll_settle;
                    st     <= S_CWAIT;
                end else begin
                    st <= S_FIN;
                end
                S_CWAIT: if (cnt == '0) st <= S_FIN; else cnt <= cnt - 1'b1;
                S_FIN: begin
                    cur_q <= tgt_q;
                    st    <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // Status decode from the state.
    always_comb begin
        busy = (st != S_IDLE);
        done = (st == S_FIN);
    end
endmodule

// File: rtl/opm_gate_chk.sv
// Derives per-block clock enables from dividers and domain power states,
// and records the first functional access to a gated block that cannot
// wake itself. Block b belongs to domain b / BLK_PER_DOM.
module opm_gate_chk #(
    parameter int NUM_DOM     = 2,
    parameter int BLK_PER_DOM = 2,
    parameter int DIV_W       = 4,
    localparam int NUM_BLK    = NUM_DOM * BLK_PER_DOM,
    localparam int BLK_W      = $clog2(NUM_BLK),
    parameter logic [NUM_BLK-1:0] WAKE_MASK = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [2*NUM_DOM-1:0]       pwr,
    input  logic [NUM_BLK*DIV_W-1:0]   div,
    input  logic [NUM_BLK-1:0]         acc_valid,
    input  logic                       clr,
    output logic [NUM_BLK-1:0]         clk_en,
    output logic                       err_q,
    output logic [BLK_W-1:0]           err_blk_q
);
    import opm_pkg::*;

    logic [NUM_BLK-1:0] bad;
    logic [BLK_W-1:0]   first_bad;

    // Per-block enable: nonzero divider and a powered domain.
    for (genvar b = 0; b < NUM_BLK; b++) begin : g_en
        assign clk_en[b] = (div[b*DIV_W +: DIV_W] != '0) &&
                           (pwr[2*(b/BLK_PER_DOM) +: 2] != PWR_OFF);
    end

    // Offending accesses and the lowest offending block number.
    always_comb begin
        bad       = acc_valid & ~clk_en & ~WAKE_MASK;
        first_bad = '0;
        for (int b = NUM_BLK - 1; b >= 0; b--) begin
            if (bad[b]) first_bad = BLK_W'(b);
        end
    end

    // Sticky error record; a new error outranks a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q     <= 1'b0;
            err_blk_q <= '0;
        end else if (|bad && (!err_q || clr)) begin
            err_q     <= 1'b1;
            err_blk_q <= first_bad;
        end else if (clr) begin
            err_q <= 1'b0;
        end
    end
endmodule

// File: rtl/opm_ctrl.sv
// Top of the operating-point manager: register decode, request admission,
// sticky flags, and the tables, sequencer and gate checker.
// Assumes SET_W <= 8 and NUM_DOM <= 2 so fields fit their data lanes.
module opm_ctrl #(
    parameter int NUM_OPP     = 4,
    parameter int NUM_PST     = 4,
    parameter int NUM_CST     = 4,
    parameter int NUM_DOM     = 2,
    parameter int BLK_PER_DOM = 2,
    parameter int DIV_W       = 4,
    parameter int PLL_W       = 4,
    parameter int SET_W       = 8,
    localparam int NUM_BLK    = NUM_DOM * BLK_PER_DOM,
    localparam int OPP_W      = $clog2(NUM_OPP),
    localparam int BLK_W      = $clog2(NUM_BLK),
    parameter logic [NUM_BLK-1:0] WAKE_MASK = 4'b1000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en_i,
    input  logic [7:0]                  wr_addr_i,
    input  logic [31:0]                 wr_data_i,
    input  logic [NUM_BLK-1:0]          acc_valid_i,
    output logic [2*NUM_DOM-1:0]        pwr_state_o,
    output logic [NUM_BLK*DIV_W-1:0]    clk_div_o,
    output logic [NUM_BLK-1:0]          clk_en_o,
    output logic [NUM_DOM*PLL_W-1:0]    pll_mul_o,
    output logic [NUM_DOM*PLL_W-1:0]    pll_div_o,
    output logic                        busy_o,
    output logic                        done_o,
    output logic [OPP_W-1:0]            cur_opp_o,
    output logic                        ovr_flag_o,
    output logic                        inv_flag_o,
    output logic                        err_flag_o,
    output logic [BLK_W-1:0]            err_blk_o
);
    import opm_pkg::*;

    logic               req_wr, idx_ok, start, clr_wr;
    logic [SET_W-1:0]   pwr_settle_q, pll_settle_q;
    logic [OPP_W-1:0]   tgt;
    logic [2*NUM_DOM-1:0]     row_pwr;
    logic [NUM_BLK*DIV_W-1:0] row_div;
    logic [NUM_DOM*PLL_W-1:0] row_mul, row_pdiv;

    // Request and clear decode.
    always_comb begin
        req_wr = wr_en_i && wr_addr_i == A_REQ;
        idx_ok = wr_data_i < 32'(NUM_OPP);
        start  = req_wr && !busy_o && idx_ok;
        clr_wr = wr_en_i && wr_addr_i == A_CLR;
    end

    // Settling counts, writable only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_settle_q <= '0;
            pll_settle_q <= '0;
        end else if (wr_en_i && wr_addr_i == A_SETTLE && !busy_o) begin
            pwr_settle_q <= wr_data_i[SET_W-1:0];
            pll_settle_q <= wr_data_i[8 +: SET_W];
        end
    end

    // Sticky overrun and invalid-index flags; setting outranks clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_flag_o <= 1'b0;
            inv_flag_o <= 1'b0;
        end else begin
            if (req_wr && busy_o)                 ovr_flag_o <= 1'b1;
            else if (clr_wr && wr_data_i[0])      ovr_flag_o <= 1'b0;
            if (req_wr && !busy_o && !idx_ok)     inv_flag_o <= 1'b1;
            else if (clr_wr && wr_data_i[1])      inv_flag_o <= 1'b0;
        end
    end

    opm_tables #(
        .NUM_OPP(NUM_OPP), .NUM_PST(NUM_PST), .NUM_CST(NUM_CST),
        .NUM_DOM(NUM_DOM), .NUM_BLK(NUM_BLK), .DIV_W(DIV_W), .PLL_W(PLL_W)
    ) u_tables (
        .clk(clk), .rst_n(rst_n), .tab_we(wr_en_i && !busy_o),
        .wr_addr(wr_addr_i), .wr_data(wr_data_i), .sel_opp(tgt),
        .row_pwr(row_pwr), .row_div(row_div), .row_mul(row_mul), .row_pdiv(row_pdiv)
    );

    opm_seq #(
        .NUM_OPP(NUM_OPP), .NUM_DOM(NUM_DOM), .NUM_BLK(NUM_BLK),
        .DIV_W(DIV_W), .PLL_W(PLL_W), .SET_W(SET_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_idx(wr_data_i[OPP_W-1:0]),
        .row_pwr(row_pwr), .row_div(row_div), .row_mul(row_mul), .row_pdiv(row_pdiv),
        .pwr_settle(pwr_settle_q), .pll_settle(pll_settle_q),
        .pwr_q(pwr_state_o), .div_q(clk_div_o), .mul_q(pll_mul_o), .pdiv_q(pll_div_o),
        .tgt_q(tgt), .cur_q(cur_opp_o), .busy(busy_o), .done(done_o)
    );

    opm_gate_chk #(
        .NUM_DOM(NUM_DOM), .BLK_PER_DOM(BLK_PER_DOM), .DIV_W(DIV_W), .WAKE_MASK(WAKE_MASK)
    ) u_gate (
        .clk(clk), .rst_n(rst_n), .pwr(pwr_state_o), .div(clk_div_o),
        .acc_valid(acc_valid_i), .clr(clr_wr && wr_data_i[2]),
        .clk_en(clk_en_o), .err_q(err_flag_o), .err_blk_q(err_blk_o)
    );
endmodule

// File: rtl/opm_ctrl_sva.sv
// Temporal checks on the manager's ports, bound to every opm_ctrl instance.
module opm_ctrl_sva #(
    parameter int NUM_OPP = 4,
    parameter int NUM_DOM = 2,
    parameter int NUM_BLK = 4,
    parameter logic [NUM_BLK-1:0] WAKE_MASK = '0
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en_i,
    input logic [7:0]             wr_addr_i,
    input logic [31:0]            wr_data_i,
    input logic [NUM_BLK-1:0]     acc_valid_i,
    input logic [2*NUM_DOM-1:0]   pwr_state_o,
    input logic [NUM_BLK-1:0]     clk_en_o,
    input logic                   busy_o,
    input logic                   done_o,
    input logic                   ovr_flag_o,
    input logic                   inv_flag_o,
    input logic                   err_flag_o
);
    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);                                            // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                           // R2
    AST_PWR_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(pwr_state_o));                             // R3
    AST_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == 8'h00 && busy_o) |=> ovr_flag_o);     // R7
    AST_INVALID_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == 8'h00 && !busy_o && wr_data_i >= 32'(NUM_OPP))
        |=> (inv_flag_o && !busy_o));                                  // R8
    AST_GATED_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(acc_valid_i & ~clk_en_o & ~WAKE_MASK)) |=> err_flag_o);     // R10
endmodule

bind opm_ctrl opm_ctrl_sva #(
    .NUM_OPP(NUM_OPP), .NUM_DOM(NUM_DOM), .NUM_BLK(NUM_BLK), .WAKE_MASK(WAKE_MASK)
) u_sva (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .acc_valid_i(acc_valid_i), .pwr_state_o(pwr_state_o),
    .clk_en_o(clk_en_o), .busy_o(busy_o), .done_o(done_o),
    .ovr_flag_o(ovr_flag_o), .inv_flag_o(inv_flag_o), .err_flag_o(err_flag_o)
);

// File: tb/opm_ctrl_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module opm_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [7:0]  wr_addr_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [3:0]  acc_valid_i = '0;
    logic [3:0]  pwr_state_o;
    logic [15:0] clk_div_o;
    logic [3:0]  clk_en_o;
    logic [7:0]  pll_mul_o, pll_div_o;
    logic        busy_o, done_o, ovr_flag_o, inv_flag_o, err_flag_o;
    logic [1:0]  cur_opp_o, err_blk_o;

    int n_chk = 0;
    int n_bad = 0;
    localparam int P = 5;
    localparam int Q = 3;

    always #4 clk = ~clk;

    opm_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .acc_valid_i(acc_valid_i), .pwr_state_o(pwr_state_o),
        .clk_div_o(clk_div_o), .clk_en_o(clk_en_o), .pll_mul_o(pll_mul_o),
        .pll_div_o(pll_div_o), .busy_o(busy_o), .done_o(done_o), .cur_opp_o(cur_opp_o),
        .ovr_flag_o(ovr_flag_o), .inv_flag_o(inv_flag_o), .err_flag_o(err_flag_o),
        .err_blk_o(err_blk_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    // Request a row and count busy cycles and done pulses.
    task automatic request(logic [31:0] idx, int exp_cyc, string req);
        int cyc = 0;
        int dones = 0;
        reg_wr(8'h00, idx);
        while (busy_o && cyc < 1000) begin
            cyc++;
            if (done_o) dones++;
            @(negedge clk);
        end
        check({req, " busy cycles"}, cyc, exp_cyc);
        check({req, " done pulses"}, dones, 1);
        check({req, " cur_opp"}, cur_opp_o, idx);
    endtask

    task automatic t_reset;
        check("R1 pwr", pwr_state_o, 4'b1010);
        check("R1 div", clk_div_o, 16'h1111);
        check("R1 en", clk_en_o, 4'hF);
        check("R1 pll", {pll_mul_o, pll_div_o}, 16'h1111);
        check("R1 status", {busy_o, done_o, ovr_flag_o, inv_flag_o, err_flag_o, cur_opp_o}, 0);
    endtask

    task automatic t_load;
        reg_wr(8'h01, 32'h0000_0305);
        reg_wr(8'h11, 32'h1324_0101);
        reg_wr(8'h12, 32'h1324_0102);
        reg_wr(8'h13, 32'h1324_0002);
        reg_wr(8'h21, 32'h6);
        reg_wr(8'h22, 32'h2);
        reg_wr(8'h31, 32'h1302);
    endtask

    task automatic t_both;
        request(1, 5 + P + Q, "R2 both");
        check("R5 pwr row", pwr_state_o, 4'b0110);
        check("R5 div row", clk_div_o, 16'h1302);
        check("R5 pll mul", pll_mul_o, 8'h34);
        check("R5 pll div", pll_div_o, 8'h12);
        check("R6 en zero div", clk_en_o, 4'b1101);
    endtask

    task automatic t_same;
        request(1, 3, "R4 same row");
    endtask

    task automatic t_pwr_only;
        request(2, 3 + P + 1, "R3 power only");
        check("R3 pwr", pwr_state_o, 4'b0010);
        check("R6 en domain off", clk_en_o, 4'b0001);
    endtask

    task automatic t_clk_only;
        request(3, 3 + Q + 1, "R4 clock only");
        check("R4 div", clk_div_o, 16'h1111);
        check("R6 en", clk_en_o, 4'b0011);
    endtask

    task automatic t_overrun;
        int w = 0;
        reg_wr(8'h00, 0);
        reg_wr(8'h00, 2);
        reg_wr(8'h22, 32'hA);
        reg_wr(8'h01, 32'h0);
        while (busy_o && w < 1000) begin w++; @(negedge clk); end
        check("R7 ovr", ovr_flag_o, 1);
        check("R7 target kept", cur_opp_o, 0);
        check("R7 pwr", pwr_state_o, 4'b1010);
        request(2, 5 + P + Q, "R9 settle unchanged");
        check("R9 pst row unchanged", pwr_state_o, 4'b0010);
    endtask

    task automatic t_invalid;
        reg_wr(8'h00, 4);
        check("R8 inv", inv_flag_o, 1);
        check("R8 idle", busy_o, 0);
        check("R8 state", {cur_opp_o, pwr_state_o, clk_div_o}, {2'd2, 4'b0010, 16'h1302});
        reg_wr(8'h02, 32'h3);
        check("R11 clear", {ovr_flag_o, inv_flag_o}, 0);
    endtask

    task automatic access(logic [3:0] m);
        @(negedge clk); acc_valid_i = m;
        @(negedge clk); acc_valid_i = '0;
    endtask

    task automatic t_errors;
        access(4'b1000);
        check("R10 wake block no error", err_flag_o, 0);
        access(4'b0001);
        check("R10 enabled no error", err_flag_o, 0);
        access(4'b0100);
        check("R10 error", {err_flag_o, err_blk_o}, {1'b1, 2'd2});
        access(4'b0010);
        check("R10 first kept", err_blk_o, 2);
        reg_wr(8'h02, 32'h4);
        check("R11 err clear", err_flag_o, 0);
        access(4'b0110);
        check("R10 lowest block", {err_flag_o, err_blk_o}, {1'b1, 2'd1});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_both();
        t_same();
        t_pwr_only();
        t_clk_only();
        t_overrun();
        t_invalid();
        t_errors();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule